// File: doc/BRIEF.md
# Reset and Boot Sequencer

This block turns an external active-low reset pin into the internal master reset of a processor core and decides how execution starts once that reset ends. While the internal reset is active it drives three level outputs: one empties every stack pointer, one masks all interrupts and one clears the mode/status register. The first reset after power is applied is stretched until a lock timer has counted `LOCK_CYCLES` clocks, so the clock generator has time to settle. Later (warm) resets release as soon as the pin does, because the clock never stopped.

The reset pin passes through a synchronizer chain and a glitch filter. Low pulses shorter than `MIN_PULSE` sampled cycles never reach the core. When the internal reset ends, a mode strap picks the start path. With the strap at 1, fetching from address zero begins at once. With the strap at 0, the block sends a one-cycle start pulse to the boot loader, deferred while a bus request is pending. It then enables fetching once the loader reports completion. Fetch enable stays high until the next internal reset.

Top module: `reset_boot_sequencer`

## Requirements
- R1: While `por_n` is low, `sp_clear`, `irq_mask_all` and `status_clear` are 1, and `boot_start` and `fetch_en` are 0.
- R2: After `por_n` rises with the pin high, the internal reset stays asserted for exactly `LOCK_CYCLES` clock edges and drops on edge `LOCK_CYCLES`+1. A pin held low past the lock time extends it.
- R3: Once the lock wait has been served, the internal reset drops on the 4th rising edge after the pin rises, with no further lock wait.
- R4: A pin low for L sampled cycles with L < `MIN_PULSE` (default 4) has no effect. With L >= `MIN_PULSE`, internal reset asserts on edge `MIN_PULSE`+3 after the fall and stays high for L+1-`MIN_PULSE` cycles.
- R5: `sp_clear`, `irq_mask_all` and `status_clear` are always equal. Each is 1 exactly while the internal reset is active.
- R6: With strap 0 and no bus request, `boot_start` is 1 for exactly one cycle, on the edge where the internal reset drops.
- R7: With strap 0 and `bus_req` high at release, `boot_start` stays 0 while the request holds. It pulses on the first edge that samples `bus_req` low.
- R8: With strap 1, `fetch_en` rises on the edge where the internal reset drops, and `boot_start` stays 0.
- R9: On the boot path, `fetch_en` rises on the edge that samples `boot_done` high. It then stays 1 until the next internal reset.
- R10: `fetch_en` is 0 in every cycle in which the internal reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| por_n | input | 1 | Active-low power-on reset; clears the lock-done flag |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| bus_req | input | 1 | External bus request pending |
| mode_strap | input | 1 | 0: boot load first, 1: direct start at address zero |
| boot_done | input | 1 | Boot loader completion handshake |
| sp_clear | output | 1 | Force all stack pointers empty |
| irq_mask_all | output | 1 | Mask every interrupt |
| status_clear | output | 1 | Clear the mode/status register |
| boot_start | output | 1 | One-cycle request to start boot loading |
| fetch_en | output | 1 | Fetch from program address 0x0000 enabled |

## Verification
A pin edge reaches the reset outputs four rising edges later: two synchronizer stages, the filter register and the state register. A qualifying assertion therefore shows `MIN_PULSE`+3 edges after the fall. `boot_start`, and `fetch_en` on the direct path, change on the same edge as the reset release. `fetch_en` on the boot path, and a deferred `boot_start`, follow one edge after the sampled `boot_done` or `bus_req` change. The bench drives every input on the falling edge and compares all outputs at each following falling edge against a per-cycle expectation built from these offsets. This covers every pulse width from 1 to `MIN_PULSE`+2 under each strap and bus-request combination, so an off-by-one cycle shows up as a mismatch at a named edge.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    typedef enum logic [1:0] {
        ST_RESET    = 2'd0,
        ST_WAIT_BUS = 2'd1,
        ST_BOOT     = 2'd2,
        ST_RUN      = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       boot_start;
    } seq_regs_t;

endpackage

// File: rtl/rbs_pin_sync.sv
module rbs_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n_i,
    output logic pin_n_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            assign chain_d = pin_n_i;
        end else begin : g_multi
            assign chain_d = {chain_q[STAGES-2:0], pin_n_i};
        end
    endgenerate

    // Reset value 0: the pin reads as asserted until the chain has sampled it.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign pin_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/rbs_pulse_filter.sv
module rbs_pulse_filter #(
    parameter int MIN_PULSE = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n_s,
    output logic rst_req
);
    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] CMAX = CW'(MIN_PULSE);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          req_d, req_q;

    always_comb begin
        cnt_d = cnt_q;
        req_d = req_q;
        if (pin_n_s) begin
            cnt_d = '0;
            req_d = 1'b0;
        end else begin
            if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
            if (cnt_q == CMAX - 1'b1) req_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= CMAX;
            req_q <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
            req_q <= req_d;
        end
    end

    assign rst_req = req_q;

    assert_min_width_R4: assert property (@(posedge clk) disable iff (!por_n)
        $rose(req_q) |-> $past(cnt_q) == CMAX - 1'b1);
endmodule

// File: rtl/rbs_lock_timer.sv
module rbs_lock_timer #(
    parameter int LOCK_CYCLES = 2000
) (
    input  logic clk,
    input  logic por_n,
    output logic lock_done
);
    localparam int TW = $clog2(LOCK_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(LOCK_CYCLES - 1);

    logic [TW-1:0] cnt_d, cnt_q;
    logic          done_d, done_q;

    always_comb begin
        cnt_d  = cnt_q;
        done_d = done_q;
        if (!done_q) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST) done_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            done_q <= done_d;
        end
    end

    assign lock_done = done_q;

    assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!por_n)
        done_q |=> done_q);
endmodule

// File: rtl/reset_boot_sequencer.sv
module reset_boot_sequencer
    import rbs_pkg::*;
#(
    parameter int LOCK_CYCLES = 2000,
    parameter int MIN_PULSE   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin_n,
    input  logic bus_req,
    input  logic mode_strap,
    input  logic boot_done,
    output logic sp_clear,
    output logic irq_mask_all,
    output logic status_clear,
    output logic boot_start,
    output logic fetch_en
);
    logic pin_n_s;
    logic rst_req;
    logic lock_done;

    rbs_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .por_n   (por_n),
        .pin_n_i (rst_pin_n),
        .pin_n_o (pin_n_s)
    );

    rbs_pulse_filter #(.MIN_PULSE(MIN_PULSE)) i_filter (
        .clk     (clk),
        .por_n   (por_n),
        .pin_n_s (pin_n_s),
        .rst_req (rst_req)
    );

    rbs_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) i_timer (
        .clk       (clk),
        .por_n     (por_n),
        .lock_done (lock_done)
    );

    seq_regs_t regs_d, regs_q;

    always_comb begin
        regs_d            = regs_q;
        regs_d.boot_start = 1'b0;
        if (rst_req) begin
            regs_d.state = ST_RESET;
        end else begin
            unique case (regs_q.state)
                ST_RESET: begin
                    if (lock_done) begin
                        if (mode_strap) begin
                            regs_d.state = ST_RUN;
                        end else if (bus_req) begin
                            regs_d.state = ST_WAIT_BUS;
                        end else begin
                            regs_d.state      = ST_BOOT;
                            regs_d.boot_start = 1'b1;
                        end
                    end
                end
                ST_WAIT_BUS: begin
                    if (!bus_req) begin
                        regs_d.state      = ST_BOOT;
                        regs_d.boot_start = 1'b1;
                    end
                end
                ST_BOOT: begin
                    if (boot_done) regs_d.state = ST_RUN;
                end
                ST_RUN: regs_d.state = ST_RUN;
                default: regs_d.state = ST_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            regs_q.state      <= ST_RESET;
            regs_q.boot_start <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign sp_clear     = (regs_q.state == ST_RESET);
    assign irq_mask_all = (regs_q.state == ST_RESET);
    assign status_clear = (regs_q.state == ST_RESET);
    assign boot_start   = regs_q.boot_start;
    assign fetch_en     = (regs_q.state == ST_RUN);

    assert_cold_hold_R2: assert property (@(posedge clk) disable iff (!por_n)
        !lock_done |=> sp_clear);

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!por_n)
        boot_start |=> !boot_start);

    assert_bus_gate_R7: assert property (@(posedge clk) disable iff (!por_n)
        boot_start |-> !$past(bus_req));

    assert_fetch_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
        (fetch_en && !rst_req) |=> fetch_en);

    assert_no_fetch_R10: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> (!fetch_en && sp_clear));

    assert_direct_no_boot_R8: assert property (@(posedge clk) disable iff (!por_n)
        (sp_clear && !rst_req && lock_done && mode_strap) |=> (fetch_en && !boot_start));
endmodule

// File: tb/test_reset_boot_sequencer.sv
module test_reset_boot_sequencer;
    localparam int LOCK = 2000;
    localparam int MINP = 4;

    logic clk = 1'b0;
    logic por_n, rst_pin_n, bus_req, mode_strap, boot_done;
    logic sp_clear, irq_mask_all, status_clear, boot_start, fetch_en;

    int vectors = 0;
    int errors  = 0;

    always #5 clk = ~clk;

    reset_boot_sequencer #(.LOCK_CYCLES(LOCK), .MIN_PULSE(MINP), .SYNC_STAGES(2)) i_reset_boot_sequencer (
        .clk          (clk),
        .por_n        (por_n),
        .rst_pin_n    (rst_pin_n),
        .bus_req      (bus_req),
        .mode_strap   (mode_strap),
        .boot_done    (boot_done),
        .sp_clear     (sp_clear),
        .irq_mask_all (irq_mask_all),
        .status_clear (status_clear),
        .boot_start   (boot_start),
        .fetch_en     (fetch_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_rst(input string req, input int exp);
        chk(req, sp_clear, exp);
        chk("R5 mask", irq_mask_all, sp_clear);
        chk("R5 status", status_clear, sp_clear);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        por_n = 1'b0; rst_pin_n = 1'b1; bus_req = 1'b0; mode_strap = 1'b1; boot_done = 1'b0;
        step(3);
        // R1: state while power-on reset is held
        chk_rst("R1", 1);
        chk("R1 fetch", fetch_en, 0);
        chk("R1 boot", boot_start, 0);

        // R2: cold release, lock wait of LOCK edges, direct start (R8)
        por_n = 1'b1;
        for (int i = 1; i <= LOCK + 1; i++) begin
            step(1);
            chk_rst("R2", (i <= LOCK) ? 1 : 0);
            chk("R8 fetch", fetch_en, (i <= LOCK) ? 0 : 1);
            chk("R8 boot", boot_start, 0);
        end

        // Sweep of warm pulses: strap, bus request and pulse width
        for (int s = 0; s < 2; s++) begin
            for (int b = 0; b < 2; b++) begin
                for (int L = 1; L <= MINP + 2; L++) begin
                    bit hit;
                    hit = (L >= MINP);
                    mode_strap = s[0];
                    bus_req    = b[0];
                    rst_pin_n  = 1'b0;
                    for (int i = 1; i <= L + 8; i++) begin
                        bit er, ef, eb;
                        if (i == L + 1) rst_pin_n = 1'b1;
                        step(1);
                        er = hit && (i >= MINP + 3) && (i <= L + 3);
                        ef = !hit || (i < MINP + 3) || (s == 1 && i >= L + 4);
                        eb = hit && s == 0 && b == 0 && (i == L + 4);
                        chk_rst("R4 R3", er);
                        chk("R10 R8 fetch", fetch_en, ef);
                        chk("R6 boot_start", boot_start, eb);
                    end
                    if (hit && s == 0) begin
                        if (b == 1) begin
                            chk("R7 held", boot_start, 0);
                            bus_req = 1'b0;
                            step(1);
                            chk("R7 pulse", boot_start, 1);
                            step(1);
                            chk("R6 one cycle", boot_start, 0);
                        end
                        chk("R9 wait", fetch_en, 0);
                        boot_done = 1'b1;
                        step(1);
                        boot_done = 1'b0;
                        chk("R9 fetch", fetch_en, 1);
                        step(3);
                        chk("R9 sticky", fetch_en, 1);
                    end
                end
            end
        end

        // Second cold start with the pin held low past the lock time, boot path
        por_n = 1'b0; rst_pin_n = 1'b0; mode_strap = 1'b0; bus_req = 1'b0;
        step(2);
        chk_rst("R1", 1);
        por_n = 1'b1;
        step(LOCK + 20);
        chk_rst("R2 pin low", 1);
        rst_pin_n = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            step(1);
            chk_rst("R3 release", (i <= 3) ? 1 : 0);
            chk("R6 boot_start", boot_start, (i == 4) ? 1 : 0);
        end
        step(1);
        chk("R6 one cycle", boot_start, 0);
        step(5);
        chk("R9 waits", fetch_en, 0);
        boot_done = 1'b1;
        step(1);
        boot_done = 1'b0;
        chk("R9 fetch", fetch_en, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule